// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital control side of an analog-to-digital converter. Software drives it through a single 8-bit control/status register that holds a completion flag, an interrupt enable, a run bit, a scan-mode bit and a channel select field. From that register the block issues one-cycle start pulses with a channel number to the converter and waits for the converter's done pulse before it moves on.

In single mode one channel is converted, and then the run bit drops by itself. In scan mode the channels from 0 up to the selected one are converted in ascending order. The flag is raised at the end of each pass, and the sequence wraps to channel 0 and repeats until the run bit is cleared. Conversions can also be launched from an external trigger pin. That pin is synchronised with two flip-flops and acts on its rising edge. A standby input halts everything.

The completion flag has a guarded clear. A software write of 0 only clears it if a register read has already observed it at 1. A DMA access to the conversion result also clears it. The interrupt request is the flag gated by the enable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register field reads 0, irq is low and conv_start is low.
- R2: Register layout: bit 7 flag, bit 6 interrupt enable, bit 5 run, bit 4 scan (1 = scan, 0 = single), bit 3 reads 0, bits 2:0 channel select. Interrupt enable is written on every register write.
- R3: In single mode, setting run issues exactly one conversion on the selected channel. When the done pulse arrives, the flag sets and run clears in the same cycle.
- R4: In scan mode, channels 0 to the selected value are converted in ascending order. The flag sets when the selected channel completes, then the sequence wraps to channel 0 while run stays 1.
- R5: A software write of run = 0 stops a scan, and no further conv_start pulse follows.
- R6: irq is high exactly when both the flag and the interrupt enable are 1.
- R7: A write with bit 7 = 0 clears the flag only if a read since the flag last set saw it at 1. Otherwise the flag is unchanged. Writing 1 to bit 7 never sets the flag.
- R8: A dma_ack pulse clears the flag.
- R9: While run is 1, writes leave the scan bit and the channel select field unchanged.
- R10: A rising edge on trig_in, seen through a two-stage synchroniser, sets run when run is 0.
- R11: A trigger edge that arrives while run is 1 has no effect; no extra conversion results.
- R12: standby clears run and halts conversion. While standby is high, writes of run = 1 are ignored.
- R13: conv_start is a one-cycle pulse, and conv_chan carries the channel in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| trig_in | input | 1 | Asynchronous external start trigger |
| standby | input | 1 | Halts conversion and holds run at 0 |
| dma_ack | input | 1 | DMA has read the conversion result |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CH_W | Channel for the conversion being started |
| irq | output | 1 | Conversion-end interrupt request |

## Verification
A register write is visible on reg_rdata one cycle after its strobe. Setting run produces conv_start one cycle later. A done pulse updates the flag, run and irq on the edge that samples it. A trigger edge reaches run about three cycles after the pin rises. Every check samples at the falling clock edge, after a settling wait longer than these latencies, or after a bounded poll on the flag. Stop and standby checks take a snapshot of the conversion count and compare it again twenty cycles later, which rules out a late pulse. The bench sweeps all eight channels in single mode with the interrupt enable at 0 and at 1, and all eight scan lengths, comparing the logged channel order against an ascending sequence.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the A/D control sequencer.
// Assumes an 8-bit control register with the channel field at its LSBs.
package adc_seq_pkg;
    localparam int CSR_W     = 8;
    localparam int FLAG_BIT  = 7;
    localparam int IEN_BIT   = 6;
    localparam int RUN_BIT   = 5;
    localparam int SCAN_BIT  = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/adc_trig_sync.sv
// Brings the asynchronous trigger pin into the clock domain and flags
// its rising edges. Assumes the pin is held for at least two cycles.
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic [STAGES:0] shift_q;

    // Purpose: synchroniser chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], trig_in};
    end

    assign trig_rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/adc_csr.sv
// Control/status register: flag with guarded clear, interrupt enable,
// run bit, scan bit and channel select. Assumes CH_W <= 4.
module adc_csr
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [CSR_W-1:0] wdata,
    input  logic             standby,
    input  logic             trig_rise,
    input  logic             set_flag,
    input  logic             clr_run,
    input  logic             dma_ack,
    output logic [CSR_W-1:0] rdata,
    output logic             flag,
    output logic             ien,
    output logic             run,
    output logic             scan,
    output logic [CH_W-1:0]  sel,
    output logic             seen
);
    logic            flag_q, ien_q, run_q, scan_q, seen_q;
    logic [CH_W-1:0] sel_q;
    logic            flag_n, run_n, seen_n;

    // Purpose: next-state for run, flag and the flag-seen latch.
    always_comb begin
        run_n = run_q;
        if (standby)                      run_n = 1'b0;
        else if (wr)                      run_n = wdata[RUN_BIT];
        else if (clr_run)                 run_n = 1'b0;
        else if (trig_rise && !run_q)     run_n = 1'b1;

        flag_n = flag_q;
        if (set_flag)                     flag_n = 1'b1;
        else if (dma_ack)                 flag_n = 1'b0;
        else if (wr && !wdata[FLAG_BIT] && seen_q) flag_n = 1'b0;

        seen_n = seen_q;
        if (!flag_n)                      seen_n = 1'b0;
        else if (rd && flag_q)            seen_n = 1'b1;
    end

    // Purpose: register update; mode fields locked while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            run_q  <= 1'b0;
            scan_q <= 1'b0;
            seen_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            flag_q <= flag_n;
            run_q  <= run_n;
            seen_q <= seen_n;
            if (wr) ien_q <= wdata[IEN_BIT];
            if (wr && !run_q) begin
                scan_q <= wdata[SCAN_BIT];
                sel_q  <= wdata[CH_W-1:0];
            end
        end
    end

    // Purpose: assemble read data; unused bits read 0.
    always_comb begin
        rdata           = '0;
        rdata[FLAG_BIT] = flag_q;
        rdata[IEN_BIT]  = ien_q;
        rdata[RUN_BIT]  = run_q;
        rdata[SCAN_BIT] = scan_q;
        rdata[CH_W-1:0] = sel_q;
    end

    assign flag = flag_q;
    assign ien  = ien_q;
    assign run  = run_q;
    assign scan = scan_q;
    assign sel  = sel_q;
    assign seen = seen_q;
endmodule

// File: rtl/adc_sequencer.sv
// Issues start pulses and steps channels in single or scan mode.
// Assumes the converter answers each start with exactly one done pulse.
module adc_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            scan,
    input  logic [CH_W-1:0] sel,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            set_flag,
    output logic            clr_run,
    output logic            busy
);
    seq_state_t      state_q;
    logic [CH_W-1:0] ch_q;
    logic            start_q;
    logic            done_ok;

    // Purpose: decode completion events for the register block.
    always_comb begin
        done_ok  = (state_q == SEQ_WAIT) && conv_done && run;
        set_flag = done_ok && (!scan || ch_q == sel);
        clr_run  = done_ok && !scan;
    end

    // Purpose: launch, wait and advance the channel pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ch_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (run) begin
                        start_q <= 1'b1;
                        state_q <= SEQ_WAIT;
                        if (!scan) ch_q <= sel;
                    end else begin
                        ch_q <= '0;
                    end
                end
                default: begin
                    if (!run) begin
                        state_q <= SEQ_IDLE;
                        ch_q    <= '0;
                    end else if (conv_done) begin
                        state_q <= SEQ_IDLE;
                        if (scan) ch_q <= (ch_q == sel) ? '0 : ch_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = ch_q;
    assign busy       = (state_q == SEQ_WAIT);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the A/D control sequencer: register block, trigger synchroniser
// and conversion sequencer. Assumes one clock domain apart from trig_in.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    input  logic             trig_in,
    input  logic             standby,
    input  logic             dma_ack,
    input  logic             conv_done,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             irq
);
    logic            trig_rise, set_flag, clr_run, seq_busy;
    logic            flag, ien, run, scan, flag_seen;
    logic [CH_W-1:0] sel;

    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_rise(trig_rise)
    );

    adc_csr #(.CH_W(CH_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
        .standby(standby), .trig_rise(trig_rise), .set_flag(set_flag),
        .clr_run(clr_run), .dma_ack(dma_ack), .rdata(reg_rdata),
        .flag(flag), .ien(ien), .run(run), .scan(scan), .sel(sel),
        .seen(flag_seen)
    );

    adc_sequencer #(.CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .scan(scan), .sel(sel),
        .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
        .set_flag(set_flag), .clr_run(clr_run), .busy(seq_busy)
    );

    // Purpose: interrupt request is the flag gated by the enable.
    assign irq = flag & ien;
endmodule

// File: rtl/adc_seq_chk.sv
// Property checker for adc_seq_ctrl, attached by bind.
module adc_seq_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [7:0]      reg_rdata,
    input logic            standby,
    input logic            dma_ack,
    input logic            conv_done,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input logic            irq,
    input logic            flag_seen,
    input logic            seq_busy
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R13
    AST_SCAN_ORDER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && reg_rdata[4]) |-> (conv_chan <= reg_rdata[CH_W-1:0])); // R4
    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && conv_done && reg_rdata[5] && !reg_rdata[4] && !reg_wr && !standby)
        |=> (!reg_rdata[5] && reg_rdata[7])); // R3
    AST_FLAG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !flag_seen && !dma_ack) |=> reg_rdata[7]); // R7
    AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !(seq_busy && conv_done)) |=> !reg_rdata[7]); // R8
    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rdata[5]) |=> $stable(reg_rdata[4:0])); // R9
    AST_STANDBY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !reg_rdata[5]); // R12
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[6] |-> !irq); // R6
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .standby(standby), .dma_ack(dma_ack), .conv_done(conv_done),
    .conv_start(conv_start), .conv_chan(conv_chan), .irq(irq),
    .flag_seen(flag_seen), .seq_busy(seq_busy)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    localparam int CH_W = 3;
    localparam int LAT  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic trig_in = 1'b0, standby = 1'b0, dma_ack = 1'b0;
    logic conv_done = 1'b0;
    logic conv_start, irq;
    logic [CH_W-1:0] conv_chan;

    int checks = 0, fails = 0, cycles = 0;
    int nlog = 0;
    int log_ch [0:1023];
    logic stub_busy = 1'b0;
    int stub_cnt = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .standby(standby), .dma_ack(dma_ack), .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan), .irq(irq)
    );

    // Behavioural converter: logs each start, answers after LAT cycles.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (stub_busy) begin
            if (stub_cnt == 0) begin
                conv_done <= 1'b1;
                stub_busy <= 1'b0;
            end else stub_cnt <= stub_cnt - 1;
        end else if (conv_start) begin
            stub_busy <= 1'b1;
            stub_cnt  <= LAT - 1;
            if (nlog < 1024) log_ch[nlog] <= int'(conv_chan);
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_flag(input string tag);
        int n = 0;
        @(negedge clk);
        while (!reg_rdata[7] && n < 1000) begin @(negedge clk); n++; end
        chk(reg_rdata[7], tag, 0, 1);
    endtask

    task automatic clear_flag(input logic [7:0] keep);
        logic [7:0] v;
        rd(v);
        wr(keep & 8'h7F);
    endtask

    task automatic trig_pulse();
        @(negedge clk); trig_in = 1'b1;
        wait_cyc(3); trig_in = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        int base, snap;
        wait_cyc(3);
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R1 reset register", reg_rdata, 0);
        chk(!irq && !conv_start, "R1 reset outputs", {irq, conv_start}, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 layout, bit 3 reads 0; R7 writing 1 to flag does not set it
        wr(8'hDD); @(negedge clk);
        chk(reg_rdata == 8'h55, "R2 R7 layout", reg_rdata, 8'h55);
        wr(8'h00);

        // R3 R6 R7 R13 single-mode sweep
        for (int ie = 0; ie < 2; ie++) begin
            for (int c = 0; c < 8; c++) begin
                base = nlog;
                wr(8'((ie << 6) | 8'h20 | c));
                wait_flag("R3 single flag");
                wait_cyc(LAT + 4);
                chk(nlog - base == 1, "R3 R13 one conversion", nlog - base, 1);
                chk(log_ch[base] == c, "R3 channel", log_ch[base], c);
                chk(!reg_rdata[5], "R3 run auto-clear", reg_rdata[5], 0);
                chk(irq == ie[0], "R6 irq", irq, ie);
                wr(8'(ie << 6)); @(negedge clk);
                chk(reg_rdata[7], "R7 clear without read", reg_rdata[7], 1);
                rd(v);
                wr(8'(ie << 6)); @(negedge clk);
                chk(!reg_rdata[7] && !irq, "R7 R6 clear after read", {reg_rdata[7], irq}, 0);
            end
        end

        // R4 R5 R9 scan-mode sweep
        for (int c = 0; c < 8; c++) begin
            base = nlog;
            wr(8'(8'h30 | c));
            wait_flag("R4 scan flag");
            chk(nlog - base == c + 1, "R4 pass length", nlog - base, c + 1);
            for (int i = 0; i <= c; i++)
                chk(log_ch[base + i] == i, "R4 ascending order", log_ch[base + i], i);
            chk(reg_rdata[5], "R4 run held", reg_rdata[5], 1);
            wr(8'(8'h20 | (c ^ 7)));
            rd(v);
            chk(v[4:0] == 5'(8'h10 | c), "R9 mode locked", v[4:0], 8'h10 | c);
            wr(8'(8'h30 | c));
            wait_flag("R4 second pass flag");
            chk(log_ch[base + c + 1] == 0, "R4 wrap to 0", log_ch[base + c + 1], 0);
            wr(8'h00);
            wait_cyc(10);
            snap = nlog;
            wait_cyc(20);
            chk(nlog == snap, "R5 stop", nlog - snap, 0);
            chk(!reg_rdata[5], "R5 run low", reg_rdata[5], 0);
            clear_flag(8'h00);
        end

        // R10 trigger start, R11 trigger while running ignored
        wr(8'h05);
        base = nlog;
        trig_pulse();
        wait_cyc(1);
        trig_pulse();
        wait_flag("R10 trigger flag");
        wait_cyc(20);
        chk(nlog - base == 1, "R10 R11 trigger count", nlog - base, 1);
        chk(log_ch[base] == 5, "R10 trigger channel", log_ch[base], 5);

        // R8 DMA clear
        @(negedge clk); dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0;
        chk(!reg_rdata[7], "R8 dma clear", reg_rdata[7], 0);

        // R12 standby halts scan and blocks run writes
        wr(8'h33);
        wait_cyc(15);
        @(negedge clk); standby = 1'b1;
        wr(8'h33);
        @(negedge clk);
        chk(!reg_rdata[5], "R12 run blocked", reg_rdata[5], 0);
        standby = 1'b0;
        wait_cyc(10);
        snap = nlog;
        wait_cyc(20);
        chk(nlog == snap && !reg_rdata[5], "R12 halted", nlog - snap, 0);

        summary();
    end
endmodule